// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Forced Actions

This block sits beside a free-running 16-bit counter that advances on every clock. Each of its eight channels holds a 16-bit compare value and a 2-bit pin action. When the counter steps onto a channel's compare value, that action is applied to the channel's pin and the channel's flag is raised.

Software can also fire any channel's action at once by writing a 1 to that channel's bit of a write-only trigger register. A fired action leaves the flag alone. Channel 7 is special. Whenever it has an event, it drives a chosen group of pins to fixed levels taken from an override-level register. It wins over anything channels 6 to 0 do to those pins in the same cycle.

All registers sit on a simple single-cycle bus. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `cmp_force_unit`

## Requirements
- R1: After reset, all pins are low and all flags are clear. The override-select register (address 0x02) reads 0 and the trigger register (address 0x01) reads 0.
- R2: A write to address 0x01 with bit x set applies channel x's action at that write's clock edge. The action field sits at bits [2x+1:2x] of address 0x04, encoded 00 hold, 01 invert, 10 drive low, 11 drive high. Flag x is not set.
- R3: Reads of address 0x01 always return 0x0000.
- R4: On the clock edge where the counter (readable at address 0x07) changes to the value held at address 0x08+x, channel x's action is applied and flag x is set at that same edge. Pins change only on such matches, on writes to 0x01, and on channel 7 events.
- R5: The flags read at address 0x05. Writing 1 to bit x clears flag x, and writing 0 leaves it unchanged.
- R6: When a write to 0x01 and a real match hit the same channel at the same edge, the action is applied once and the flag stays clear.
- R7: A channel 7 event is a channel 7 match or a channel 7 trigger. On such an event, every pin x whose bit is 1 at address 0x02 takes bit x of address 0x03. This overrides any same-edge action of that pin's own channel.
- R8: When bit 0 of address 0x06 is 1, the counter wrapping from 0xFFFF to 0x0000 is also a channel 7 event. It applies the override of R7 and neither applies channel 7's own action nor sets flag 7.
- R9: Addresses 0x02 and 0x03 (8 bits each) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pins | output | 8 | Compare output pins |
| flags | output | 8 | Per-channel match flags |

## Verification
Every result in this block is due exactly one clock edge after its cause. A trigger write, a clear of a flag, or a register write shows up at the first falling edge after the rising edge that took the strobe. A match shows up at the falling edge where the counter reads the compare value.

The bench drives inputs at falling edges and reads the counter through the bus. It waits until the counter sits one step before the target, checks that nothing has changed yet, and then checks the result one falling edge later. For the collision case it places the trigger write in exactly that last cycle.

// File: rtl/cmp_force_unit.sv
module cmp_force_unit #(
  parameter int CH = 8,
  parameter int TW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_wdata,
  output logic [TW-1:0] bus_rdata,
  output logic [CH-1:0] pins,
  output logic [CH-1:0] flags
);
  localparam logic [AW-1:0] A_TRIG = AW'(1);
  localparam logic [AW-1:0] A_SEL  = AW'(2);
  localparam logic [AW-1:0] A_LVL  = AW'(3);
  localparam logic [AW-1:0] A_ACT  = AW'(4);
  localparam logic [AW-1:0] A_FLAG = AW'(5);
  localparam logic [AW-1:0] A_WRAP = AW'(6);
  localparam logic [AW-1:0] A_CNT  = AW'(7);
  localparam int CMP_BASE = 8;
  localparam int LAST = CH - 1;

  logic [TW-1:0]   cnt;
  logic [TW-1:0]   cmp [CH];
  logic [2*CH-1:0] act;
  logic [CH-1:0]   mask, data7, flg, pin, pin_nx, hit, frc, clr;
  logic            wrap_en, ovf_ev, ev7;

  wire [TW-1:0] cnt_nx = cnt + 1'b1;

  assign frc    = (bus_wr && bus_addr == A_TRIG) ? bus_wdata[CH-1:0] : '0;
  assign clr    = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[CH-1:0] : '0;
  assign ovf_ev = wrap_en && (&cnt);
  assign ev7    = hit[LAST] | frc[LAST] | ovf_ev;
  assign pins   = pin;
  assign flags  = flg;

  for (genvar x = 0; x < CH; x++) begin : g_ch
    logic [1:0] a;
    logic       own;
    assign a      = act[2*x +: 2];
    assign hit[x] = (cnt_nx == cmp[x]);
    always_comb begin
      case (a)
        2'b01:   own = ~pin[x];
        2'b10:   own = 1'b0;
        2'b11:   own = 1'b1;
        default: own = pin[x];
      endcase
    end
    assign pin_nx[x] = (ev7 && mask[x]) ? data7[x]
                     : ((hit[x] | frc[x]) ? own : pin[x]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pin     <= '0;
      flg     <= '0;
      mask    <= '0;
      data7   <= '0;
      act     <= '0;
      wrap_en <= 1'b0;
      for (int i = 0; i < CH; i++) cmp[i] <= '0;
    end else begin
      cnt <= cnt_nx;
      pin <= pin_nx;
      flg <= (flg & ~clr) | (hit & ~frc);
      if (bus_wr) begin
        if (bus_addr == A_SEL)  mask    <= bus_wdata[CH-1:0];
        if (bus_addr == A_LVL)  data7   <= bus_wdata[CH-1:0];
        if (bus_addr == A_ACT)  act     <= bus_wdata[2*CH-1:0];
        if (bus_addr == A_WRAP) wrap_en <= bus_wdata[0];
        for (int i = 0; i < CH; i++)
          if (bus_addr == AW'(CMP_BASE + i)) cmp[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata = TW'(mask);
      A_LVL:   bus_rdata = TW'(data7);
      A_ACT:   bus_rdata = TW'(act);
      A_FLAG:  bus_rdata = TW'(flg);
      A_WRAP:  bus_rdata = TW'(wrap_en);
      A_CNT:   bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < CH; i++)
      if (bus_addr == AW'(CMP_BASE + i)) bus_rdata = cmp[i];
  end
endmodule

// File: rtl/cmp_force_unit_chk.sv
module cmp_force_unit_chk #(
  parameter int CH = 8,
  parameter int TW = 16,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [TW-1:0] bus_rdata,
  input logic [CH-1:0] pins,
  input logic [CH-1:0] flags,
  input logic [CH-1:0] frc,
  input logic [CH-1:0] hit,
  input logic [CH-1:0] mask,
  input logic [CH-1:0] data7,
  input logic          ev7
);
  p_trig_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> (bus_rdata == '0));

  p_trig_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & $past(frc)) == '0));

  p_flag_from_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev7 |=> (((pins ^ $past(data7)) & $past(mask)) == '0));

  p_pins_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev7 && frc == '0 && hit == '0) |=> $stable(pins));
endmodule

bind cmp_force_unit cmp_force_unit_chk #(.CH(CH), .TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pins(pins), .flags(flags), .frc(frc), .hit(hit), .mask(mask),
  .data7(data7), .ev7(ev7)
);

// File: tb/cmp_force_unit_bench.sv
module cmp_force_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pins, flags;
  int total = 0, bad = 0;
  logic [7:0] mp = '0;

  always #4 clk = ~clk;

  cmp_force_unit u_cmp_force_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(pins), .flags(flags)
  );

  // {channel, action}
  localparam logic [4:0] VEC [0:10] = '{
    {3'd0, 2'b11}, {3'd0, 2'b01}, {3'd0, 2'b01}, {3'd0, 2'b10},
    {3'd3, 2'b01}, {3'd3, 2'b00}, {3'd5, 2'b11}, {3'd5, 2'b10},
    {3'd6, 2'b01}, {3'd2, 2'b11}, {3'd7, 2'b01}
  };

  function automatic logic apply(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_until(input logic [15:0] v);
    logic [15:0] c;
    rd(5'h07, c);
    while (c != v) begin
      @(negedge clk);
      rd(5'h07, c);
    end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] r, c, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins", 16'(pins), 16'h0);
    chk("R1 flags", 16'(flags), 16'h0);
    rd(5'h02, r); chk("R1 sel", r, 16'h0);
    rd(5'h01, r); chk("R1 trig", r, 16'h0);
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      logic [2:0] ch;
      logic [1:0] a;
      ch = VEC[i][4:2]; a = VEC[i][1:0];
      wr(5'h04, 16'(a) << (2 * ch));
      wr(5'h01, 16'(1) << ch);
      mp[ch] = apply(a, mp[ch]);
      chk("R2 pins", 16'(pins), 16'(mp));
      chk("R2 flags", 16'(flags), 16'h0);
    end
    rd(5'h01, r); chk("R3 trig read", r, 16'h0);

    // R4 real match, invert on channel 2
    wr(5'h04, 16'h0010);
    rd(5'h07, c); x = c + 16'd12;
    wr(5'h0A, x);
    wait_until(x - 16'd1);
    chk("R4 before pins", 16'(pins), 16'(mp));
    chk("R4 before flags", 16'(flags), 16'h0);
    @(negedge clk);
    mp[2] = ~mp[2];
    chk("R4 pins", 16'(pins), 16'(mp));
    chk("R4 flags", 16'(flags), 16'h04);

    // R5 write-one-to-clear
    wr(5'h05, 16'h00FB);
    chk("R5 zero keeps", 16'(flags), 16'h04);
    wr(5'h05, 16'h0004);
    chk("R5 cleared", 16'(flags), 16'h0);

    // R6 trigger collides with match on channel 3
    wr(5'h04, 16'h0040);
    rd(5'h07, c); x = c + 16'd12;
    wr(5'h0B, x);
    wait_until(x - 16'd1);
    wr(5'h01, 16'h0008);
    mp[3] = ~mp[3];
    chk("R6 single invert", 16'(pins), 16'(mp));
    chk("R6 flag clear", 16'(flags), 16'h0);

    // R9 readback
    wr(5'h02, 16'h0006);
    wr(5'h03, 16'h0004);
    rd(5'h02, r); chk("R9 sel", r, 16'h0006);
    rd(5'h03, r); chk("R9 lvl", r, 16'h0004);

    // R7 real matches on 1, 2 and 7 at the same edge; ch1 high, ch2 low, ch7 hold
    wr(5'h04, 16'h0000 | (16'b11 << 2) | (16'b10 << 4));
    rd(5'h07, c); x = c + 16'd20;
    wr(5'h09, x);
    wr(5'h0A, x);
    wr(5'h0F, x);
    wait_until(x - 16'd1);
    @(negedge clk);
    mp[1] = 1'b0; mp[2] = 1'b1;
    chk("R7 match override", 16'(pins), 16'(mp));
    chk("R7 flag7", 16'(flags & 8'h80), 16'h0080);
    wr(5'h05, 16'h00FF);

    // R7 trigger of channel 7 together with channel 1
    wr(5'h03, 16'h0000);
    wr(5'h01, 16'h0082);
    mp[1] = 1'b0; mp[2] = 1'b0;
    chk("R7 trig override", 16'(pins), 16'(mp));
    wr(5'h03, 16'h0006);
    wr(5'h01, 16'h0080);
    mp[1] = 1'b1; mp[2] = 1'b1;
    chk("R7 trig levels", 16'(pins), 16'(mp));
    chk("R7 no flag", 16'(flags), 16'h0);

    // R8 counter wrap as channel 7 event
    wr(5'h04, 16'h0000);
    wr(5'h02, 16'h0000);
    wr(5'h03, 16'h0010);
    wr(5'h06, 16'h0001);
    wait_until(16'hFFFE);
    wr(5'h02, 16'h0010);
    chk("R8 before wrap", 16'(pins), 16'(mp));
    @(negedge clk);
    mp[4] = 1'b1;
    chk("R8 wrap override", 16'(pins), 16'(mp));
    rd(5'h07, r); chk("R8 counter", r, 16'h0000);

    finish_run();
  end
endmodule